// File: doc/BRIEF.md
# Rotating-Token Ring Arbiter

The block shares one resource among a ring of requesters, four by default. Every station owns a one-bit token flop, and exactly one of those flops holds a 1 at any time. A station wins when its request line is high and it holds the right to go. The right to go comes either from the station's own token flop or from the station before it in the ring, when that station is idle and holds the right itself. The grant decision is purely combinational within the cycle.

The token moves to the next station on every clock edge, whether or not anyone is asking. The starting point of the search therefore sweeps around the ring on a fixed schedule. Any requester that stays high is served within N cycles, no matter what the others do.

A ring of OR gates would form a combinational loop. The design avoids it by unrolling the chain over two laps of the ring. The token opens the chain at its own station, and two laps are enough to reach every other station once.

Top module: `token_ring_arbiter`

## Requirements
- R1: While rst_n is low, the token vector reads 1 at bit 0 only (station 0 holds the token). This applies both at power-up and when reset is asserted in the middle of operation.
- R2: On every rising clock edge with rst_n high, the token moves from station i to station (i+1) mod N, so bit i moves to bit i+1 and the top bit wraps to bit 0.
- R3: The token advances even in cycles where no station requests.
- R4: When the request vector is all zero, every grant bit is 0.
- R5: In any cycle, at most one grant bit is set.
- R6: The grant goes to the first requesting station found by scanning t, t+1, ..., t+N-1 (mod N), where t is the station holding the token in that cycle.
- R7: When the token holder requests, the grant is given to the token holder.
- R8: A grant bit is never set for a station whose request bit is low.
- R9: The token vector has exactly one bit set at all times once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; places the token at station 0 |
| req | input | N | Request line per station, bit i for station i |
| grant | output | N | Grant per station, zero or one-hot, combinational from req and token |
| token | output | N | One-hot position of the token flop holding 1 |

## Verification
Token rotation and the grant search happen in the same cycle. The delicate case is a search that starts near the top station and must wrap through station 0 while the token is about to step forward. The bench sweeps every request pattern against every token position, so each wrap distance is met with every possible blocker in front of it. Each grant is compared with a ring-order scan computed arithmetically from the expected token index, and the token itself is compared with a counter kept by the bench. Idle stretches and a reset asserted mid-run confirm that rotation never depends on the requests and that the token always restarts at station 0.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;

  // Rotate a one-hot ring vector up by one station (top bit wraps to bit 0).
  function automatic logic [63:0] ring_step(input logic [63:0] v, input int unsigned n);
    logic [63:0] r;
    r = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < n) begin
        r[(i + 1) % n] = v[i];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ring_arb_cell.sv
// One station of the ring: combines the incoming right to go with the local
// token and either grants its own requester or hands the right onward.
module ring_arb_cell (
  input  logic req_i,
  input  logic tok_i,
  input  logic try_i,
  output logic ok_o,
  output logic pass_o
);

  logic go;

  always_comb begin
    go     = tok_i | try_i;
    ok_o   = req_i & go;
    pass_o = ~req_i & go;
  end

endmodule

// File: rtl/ring_arb_token.sv
// Token flops: one per station, shifted one position per clock.
module ring_arb_token #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] tok_o
);

  logic [N-1:0] tok_q;
  logic [N-1:0] tok_d;

  always_comb begin
    tok_d = tok_q;
    for (int unsigned i = 0; i < N; i++) begin
      tok_d[(i + 1) % N] = tok_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= N'(1);
    end else begin
      tok_q <= tok_d;
    end
  end

  assign tok_o = tok_q;

endmodule

// File: rtl/ring_arb_chain.sv
// Loop-free grant chain: the ring is laid out twice in a row. The first
// position in the layout has no incoming right, so the chain only starts at
// the token station; the second lap lets it wrap past station N-1.
module ring_arb_chain #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] tok_i,
  output logic [N-1:0] grant_o
);

  localparam int unsigned SLOTS = 2 * N;

  logic [SLOTS-1:0] try_w;
  logic [SLOTS-1:0] ok_w;
  logic [SLOTS-1:0] pass_w;

  assign try_w[0] = 1'b0;

  for (genvar p = 0; p < SLOTS; p++) begin : g_slot
    localparam int unsigned STN = p % N;

    if (p > 0) begin : g_link
      assign try_w[p] = pass_w[p-1];
    end

    ring_arb_cell u_cell (
      .req_i  (req_i[STN]),
      .tok_i  (tok_i[STN]),
      .try_i  (try_w[p]),
      .ok_o   (ok_w[p]),
      .pass_o (pass_w[p])
    );
  end

  for (genvar s = 0; s < N; s++) begin : g_merge
    assign grant_o[s] = ok_w[s] | ok_w[s+N];
  end

endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [N-1:0] token
);

  logic [N-1:0] tok_w;

  ring_arb_token #(.N(N)) u_token (
    .clk   (clk),
    .rst_n (rst_n),
    .tok_o (tok_w)
  );

  ring_arb_chain #(.N(N)) u_chain (
    .req_i   (req),
    .tok_i   (tok_w),
    .grant_o (grant)
  );

  assign token = tok_w;

endmodule

// File: rtl/token_ring_arbiter_checker.sv
module token_ring_arbiter_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] grant,
  input logic [N-1:0] token
);
  import ring_arb_pkg::*;

  logic [N-1:0] tok_next;
  assign tok_next = N'(ring_step(64'(token), N));

  assert_token_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(token) == 1);

  assert_grant_onehot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  assert_idle_no_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (grant == '0));

  assert_token_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (token == $past(tok_next)));

  assert_holder_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((token & req) != '0) |-> (grant == (token & req)));

endmodule

bind token_ring_arbiter token_ring_arbiter_checker #(.N(N)) u_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .grant (grant),
  .token (token)
);

// File: tb/token_ring_arbiter_test.sv
module token_ring_arbiter_test;
  localparam int unsigned N = 4;
  localparam time CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] grant;
  logic [N-1:0] token;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  token_ring_arbiter #(.N(N)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .token (token)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_grant(input logic [N-1:0] r, input int unsigned pos);
    for (int unsigned k = 0; k < N; k++) begin
      int unsigned s;
      s = (pos + k) % N;
      if (r[s]) return N'(1) << s;
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned pos;
    rst_n = 1'b0;
    req   = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 token at reset", token, N'(1));
    check("R4 idle grant during reset", grant, '0);
    rst_n = 1'b1;
    pos = 0;

    // R6 R7 R8 R5: every request pattern against every token position
    for (int c = 0; c < 4 * N * (1 << N); c++) begin
      req = N'(c / N);
      #1;
      check("R2 token position", token, N'(1) << pos);
      check("R6 ring-order grant", grant, exp_grant(req, pos));
      if (req[pos]) check("R7 holder granted", grant, N'(1) << pos);
      check("R8 grant only to requester", grant & ~req, '0);
      @(negedge clk);
      pos = (pos + 1) % N;
    end

    // R3 R4: idle stretch, token keeps moving
    req = '0;
    for (int c = 0; c < 2 * N + 1; c++) begin
      #1;
      check("R3 token moves while idle", token, N'(1) << pos);
      check("R4 no grant while idle", grant, '0);
      @(negedge clk);
      pos = (pos + 1) % N;
    end

    // R1: reset in the middle of operation, token away from station 0
    if (pos == 0) begin
      @(negedge clk);
      pos = 1;
    end
    req = '1;
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset token", token, N'(1));
    check("R9 one token after reset", N'($countones(token)), N'(1));
    @(negedge clk);
    check("R1 token held during reset", token, N'(1));
    check("R6 grant to station 0 under reset", grant, N'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 first step after reset", token, N'(2));
    check("R5 single grant all requesting", grant, N'(2));
    finish_run();
  end

endmodule